// File: doc/BRIEF.md
# SDRAM Command Timing Legality Checker

This block is a passive monitor placed beside an SDRAM controller. Each clock it samples one decoded command for a four-bank device (an opcode, a bank number and an auto-precharge bit). It keeps a small set of per-bank and device-wide down-counters that track how long ago each relevant command was seen. When a command arrives before every window that governs it has expired, the block raises a one-cycle violation pulse together with a four-bit code that names the broken rule.

Two speed grades are supported and picked by a static input: a fast grade for a 7.5 ns clock and a slow grade for a 10 ns clock. The auto-precharge window is the sum of write recovery and precharge time. The self-refresh exit window equals the row-cycle time. A command that breaks a rule still updates the bank state, so checking continues without a restart. Write data is taken in the same cycle as the write command with a burst of one, so "last data-in" is the write cycle itself. The block does not check the data path, schedule refresh or issue commands.

Top module: `sdram_timing_guard`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every counter, marks all four banks idle, and drives `viol` low with `viol_code` = 0.
- R2: A read or write to a bank less than tRCD cycles after an activate of that bank is flagged with code 1 (tRCD = 3 in the fast grade, 2 in the slow grade).
- R3: An activate to a bank less than tRC cycles after the previous activate of that bank is flagged with code 2 (tRC = 9 fast, 7 slow). Code 2 takes precedence over codes 8, 4, 6 and 7.
- R4: A precharge to an open bank less than tRAS cycles after its activate is flagged with code 3 (tRAS = 6 fast, 5 slow).
- R5: An activate to a bank less than tRP cycles after a precharge of that bank, or after a read with auto-precharge, is flagged with code 4 (tRP = 3 fast, 2 slow).
- R6: A precharge to an open bank less than 2 cycles after a write without auto-precharge to it is flagged with code 5.
- R7: An activate less than 2 cycles after any activate, to any bank, is flagged with code 6.
- R8: An activate less than 2 cycles after a mode register set is flagged with code 7.
- R9: An activate to a bank less than tDPL+tRP cycles after a write with auto-precharge to it is flagged with code 8 (5 fast, 4 slow).
- R10: After a self-refresh exit, any command other than NOP in the next cycle is flagged with code 9. Any other non-NOP command less than tRC cycles after the exit is flagged with code 10.
- R11: A read or write to an idle bank gives code 11, and an activate to an open bank gives code 12. Any non-NOP command other than exit while in self-refresh gives code 13. So does an exit outside self-refresh, or a self-refresh entry with any bank open. Codes 13, 9 and 10 take precedence over all others.
- R12: A command sampled at a rising edge sets `viol` high for exactly the following cycle, with its code on `viol_code`. When no rule is broken, `viol` is low and the code is 0. A flagged command still changes bank state: for example, an early precharge closes the bank.
- R13: Opcodes are 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 mode register set, 6 self-refresh entry and 7 self-refresh exit. NOP never raises a violation. Reads and writes to an open bank past tRCD may issue on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| slow_grade | input | 1 | Static grade select: 0 fast, 1 slow |
| cmd | input | 3 | Command opcode (see R13) |
| bank | input | 2 | Bank addressed by the command |
| auto_pre | input | 1 | Auto-precharge flag for reads and writes |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Code of the broken rule, 0 when none |

## Verification
The verdict for a command sampled at rising edge t appears on `viol` and `viol_code` after that edge and holds until edge t+1. The bench therefore drives each command just after a falling edge and reads both outputs at the next falling edge, which isolates the verdict of exactly one command. For every timing rule and for both grades, the bench sweeps the gap between the two commands from one cycle up to one past the limit. The expected code is computed from the gap and the grade's limit, so each window is checked at the last illegal cycle and the first legal one.

// File: rtl/sdram_timing_guard.sv
`timescale 1ns/1ps
module sdram_timing_guard #(
  parameter int BW      = 2,
  parameter int CW      = 4,
  parameter int T_RCD_F = 3,
  parameter int T_RCD_S = 2,
  parameter int T_RC_F  = 9,
  parameter int T_RC_S  = 7,
  parameter int T_RAS_F = 6,
  parameter int T_RAS_S = 5,
  parameter int T_RP_F  = 3,
  parameter int T_RP_S  = 2,
  parameter int T_DPL   = 2,
  parameter int T_RRD   = 2,
  parameter int T_MRD   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slow_grade,
  input  logic [2:0]    cmd,
  input  logic [BW-1:0] bank,
  input  logic          auto_pre,
  output logic          viol,
  output logic [3:0]    viol_code
);
  localparam int NB = 1 << BW;

  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_MRS, C_SRE, C_SRX
  } cmd_e;

  logic [CW-1:0] rcd_q [NB];
  logic [CW-1:0] rc_q  [NB];
  logic [CW-1:0] ras_q [NB];
  logic [CW-1:0] rp_q  [NB];
  logic [CW-1:0] dpl_q [NB];
  logic [CW-1:0] dal_q [NB];
  logic [CW-1:0] rrd_q, mrd_q, sec_q;
  logic [NB-1:0] open_q;
  logic          sref_q, jx_q;
  logic [3:0]    code_d;

  logic [CW-1:0] ld_rcd, ld_rc, ld_ras, ld_rp, ld_dal;
  assign ld_rcd = CW'(slow_grade ? T_RCD_S - 1 : T_RCD_F - 1);
  assign ld_rc  = CW'(slow_grade ? T_RC_S - 1  : T_RC_F - 1);
  assign ld_ras = CW'(slow_grade ? T_RAS_S - 1 : T_RAS_F - 1);
  assign ld_rp  = CW'(slow_grade ? T_RP_S - 1  : T_RP_F - 1);
  assign ld_dal = CW'(T_DPL + (slow_grade ? T_RP_S : T_RP_F) - 1);

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  wire bank_open = open_q[bank];
  wire sref_bad  = sref_q ? (cmd != C_SRX) : (cmd == C_SRX || (cmd == C_SRE && |open_q));

  always_comb begin
    code_d = 4'd0;
    if (cmd != C_NOP) begin
      if (sref_bad)            code_d = 4'd13;
      else if (jx_q)           code_d = 4'd9;
      else if (sec_q != '0)    code_d = 4'd10;
      else begin
        case (cmd)
          C_ACT: begin
            if (bank_open)               code_d = 4'd12;
            else if (rc_q[bank]  != '0)  code_d = 4'd2;
            else if (dal_q[bank] != '0)  code_d = 4'd8;
            else if (rp_q[bank]  != '0)  code_d = 4'd4;
            else if (rrd_q != '0)        code_d = 4'd6;
            else if (mrd_q != '0)        code_d = 4'd7;
          end
          C_RD, C_WR: begin
            if (!bank_open)              code_d = 4'd11;
            else if (rcd_q[bank] != '0)  code_d = 4'd1;
          end
          C_PRE: begin
            if (bank_open) begin
              if (ras_q[bank] != '0)       code_d = 4'd3;
              else if (dpl_q[bank] != '0)  code_d = 4'd5;
            end
          end
          default: code_d = 4'd0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) begin
        rcd_q[i] <= '0; rc_q[i] <= '0; ras_q[i] <= '0;
        rp_q[i]  <= '0; dpl_q[i] <= '0; dal_q[i] <= '0;
      end
      rrd_q <= '0; mrd_q <= '0; sec_q <= '0;
      open_q <= '0; sref_q <= 1'b0; jx_q <= 1'b0;
      viol <= 1'b0; viol_code <= 4'd0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        rcd_q[i] <= dec(rcd_q[i]);
        rc_q[i]  <= dec(rc_q[i]);
        ras_q[i] <= dec(ras_q[i]);
        rp_q[i]  <= dec(rp_q[i]);
        dpl_q[i] <= dec(dpl_q[i]);
        dal_q[i] <= dec(dal_q[i]);
        if (bank == BW'(i)) begin
          case (cmd)
            C_ACT: begin
              open_q[i] <= 1'b1;
              rcd_q[i]  <= ld_rcd;
              rc_q[i]   <= ld_rc;
              ras_q[i]  <= ld_ras;
            end
            C_RD: if (auto_pre) begin
              open_q[i] <= 1'b0;
              rp_q[i]   <= ld_rp;
            end
            C_WR: begin
              if (auto_pre) begin
                open_q[i] <= 1'b0;
                dal_q[i]  <= ld_dal;
              end else begin
                dpl_q[i]  <= CW'(T_DPL - 1);
              end
            end
            C_PRE: if (open_q[i]) begin
              open_q[i] <= 1'b0;
              rp_q[i]   <= ld_rp;
            end
            default: ;
          endcase
        end
      end
      rrd_q <= (cmd == C_ACT) ? CW'(T_RRD - 1) : dec(rrd_q);
      mrd_q <= (cmd == C_MRS) ? CW'(T_MRD - 1) : dec(mrd_q);
      sec_q <= (cmd == C_SRX) ? ld_rc : dec(sec_q);
      if (cmd == C_SRE) sref_q <= 1'b1;
      else if (cmd == C_SRX) sref_q <= 1'b0;
      jx_q <= (cmd == C_SRX);
      viol <= (code_d != 4'd0);
      viol_code <= code_d;
    end
  end

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd == C_NOP |=> !viol) else $error("nop flagged"); // R13

  AST_COL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_RD || cmd == C_WR) && !open_q[bank] |=> viol) else $error("column to idle bank missed"); // R11

  AST_ACT_PAIR: assert property (@(posedge clk) disable iff (rst)
    $past(cmd == C_ACT && !rst) && cmd == C_ACT |=> viol) else $error("back-to-back activate missed"); // R7

  AST_EARLY_PRE: assert property (@(posedge clk) disable iff (rst)
    $past(cmd == C_ACT && !rst) && cmd == C_PRE && bank == $past(bank) |=> viol) else $error("early precharge missed"); // R4

  AST_EXIT_NEXT: assert property (@(posedge clk) disable iff (rst)
    $past(cmd == C_SRX && !rst) && cmd != C_NOP |=> viol) else $error("command after exit missed"); // R10

  AST_QUIET_CODE: assert property (@(posedge clk) disable iff (rst)
    !viol |-> viol_code == 4'd0) else $error("code without pulse"); // R12
endmodule

// File: tb/sdram_timing_guard_tb.sv
`timescale 1ns/1ps
module sdram_timing_guard_tb;
  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, MRS = 5, SRE = 6, SRX = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_grade = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic auto_pre = 1'b0;
  logic viol;
  logic [3:0] viol_code;

  int compared = 0, mismatched = 0;
  int gv, gc;
  bit done = 0;

  always #10 clk = ~clk;

  sdram_timing_guard u_dut (
    .clk(clk), .rst(rst), .slow_grade(slow_grade), .cmd(cmd), .bank(bank),
    .auto_pre(auto_pre), .viol(viol), .viol_code(viol_code)
  );

  function automatic int t_rcd(int g); return g ? 2 : 3; endfunction
  function automatic int t_rc (int g); return g ? 7 : 9; endfunction
  function automatic int t_ras(int g); return g ? 5 : 6; endfunction
  function automatic int t_rp (int g); return g ? 2 : 3; endfunction
  function automatic int t_dal(int g); return 2 + t_rp(g); endfunction

  task automatic step(input int c, input int b, input bit ap);
    cmd = 3'(c); bank = 2'(b); auto_pre = ap;
    @(negedge clk);
    gv = int'(viol); gc = int'(viol_code);
    cmd = 3'd0; auto_pre = 1'b0;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(NOP, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    nops(3);
    rst = 1'b0;
  endtask

  task automatic chk(input int ec, input string tag);
    int ev;
    ev = (ec != 0);
    compared++;
    if (gv != ev || gc != ec) begin
      mismatched++;
      $display("FAIL %s grade=%0d: got viol=%0d code=%0d, expected viol=%0d code=%0d",
               tag, slow_grade, gv, gc, ev, ec);
    end
  endtask

  task automatic run_grade(input int g);
    // R1: reset state and idle banks
    do_reset();
    gv = int'(viol); gc = int'(viol_code);
    chk(0, "R1 reset outputs");
    step(RD, 3, 0); chk(11, "R1 banks idle after reset");
    step(ACT, 0, 0); do_reset(); step(ACT, 0, 0); chk(0, "R1 counters cleared");

    // R2: activate to column
    for (int k = 1; k <= t_rcd(g) + 1; k++) begin
      do_reset(); step(ACT, 0, 0); nops(k - 1); step(RD, 0, 0);
      chk(k < t_rcd(g) ? 1 : 0, "R2 rcd sweep");
    end

    // R3: activate to activate same bank
    for (int k = t_ras(g) + 1; k <= t_rc(g) + 1; k++) begin
      do_reset(); step(ACT, 1, 0); nops(t_ras(g) - 1); step(PRE, 1, 0);
      nops(k - t_ras(g) - 1); step(ACT, 1, 0);
      chk(k < t_rc(g) ? 2 : 0, "R3 rc sweep");
    end

    // R4: activate to precharge
    for (int k = 1; k <= t_ras(g) + 1; k++) begin
      do_reset(); step(ACT, 2, 0); nops(k - 1); step(PRE, 2, 0);
      chk(k < t_ras(g) ? 3 : 0, "R4 ras sweep");
    end

    // R5: precharge to activate, read auto-precharge to activate
    for (int k = 1; k <= t_rp(g) + 1; k++) begin
      do_reset(); step(ACT, 3, 0); nops(12); step(PRE, 3, 0); nops(k - 1); step(ACT, 3, 0);
      chk(k < t_rp(g) ? 4 : 0, "R5 rp sweep");
      do_reset(); step(ACT, 1, 0); nops(12); step(RD, 1, 1); nops(k - 1); step(ACT, 1, 0);
      chk(k < t_rp(g) ? 4 : 0, "R5 read auto-precharge sweep");
    end

    // R6: write recovery
    for (int k = 1; k <= 3; k++) begin
      do_reset(); step(ACT, 2, 0); nops(10); step(WR, 2, 0); nops(k - 1); step(PRE, 2, 0);
      chk(k < 2 ? 5 : 0, "R6 dpl sweep");
    end

    // R7: activate to other bank
    for (int k = 1; k <= 3; k++) begin
      do_reset(); step(ACT, 0, 0); nops(k - 1); step(ACT, 1, 0);
      chk(k < 2 ? 6 : 0, "R7 rrd sweep");
    end

    // R8: mode register set to activate
    for (int k = 1; k <= 3; k++) begin
      do_reset(); step(MRS, 0, 0); nops(k - 1); step(ACT, 2, 0);
      chk(k < 2 ? 7 : 0, "R8 mrd sweep");
    end

    // R9: write auto-precharge to activate
    for (int k = 1; k <= t_dal(g) + 1; k++) begin
      do_reset(); step(ACT, 0, 0); nops(10); step(WR, 0, 1); nops(k - 1); step(ACT, 0, 0);
      chk(k < t_dal(g) ? 8 : 0, "R9 dal sweep");
    end

    // R10: self-refresh exit
    do_reset(); step(SRE, 0, 0); step(SRX, 0, 0); step(NOP, 0, 0); chk(0, "R10 nop after exit");
    for (int k = 1; k <= t_rc(g) + 1; k++) begin
      do_reset(); step(SRE, 0, 0); nops(2); step(SRX, 0, 0); chk(0, "R10 exit legal");
      nops(k - 1); step(MRS, 0, 0);
      chk(k == 1 ? 9 : (k < t_rc(g) ? 10 : 0), "R10 exit sweep");
    end

    // R11: protocol errors
    do_reset(); step(ACT, 0, 0); nops(12); step(ACT, 0, 0); chk(12, "R11 activate open bank");
    do_reset(); step(WR, 2, 0); chk(11, "R11 write idle bank");
    do_reset(); step(SRE, 0, 0); step(ACT, 1, 0); chk(13, "R11 activate in self-refresh");
    do_reset(); step(SRX, 0, 0); chk(13, "R11 exit outside self-refresh");
    do_reset(); step(ACT, 1, 0); nops(3); step(SRE, 0, 0); chk(13, "R11 entry with open bank");

    // R12: pulse length and state update on violation
    do_reset(); step(ACT, 3, 0); nops(1); step(PRE, 3, 0); chk(3, "R12 early precharge flagged");
    step(NOP, 0, 0); chk(0, "R12 one-cycle pulse");
    nops(5); step(RD, 3, 0); chk(11, "R12 flagged precharge closed bank");

    // R13: back-to-back column commands
    do_reset(); step(ACT, 1, 0); nops(t_rcd(g) - 1);
    step(RD, 1, 0); chk(0, "R13 first column");
    step(RD, 1, 0); chk(0, "R13 read after read");
    step(WR, 1, 0); chk(0, "R13 write after read");
    step(WR, 1, 0); chk(0, "R13 write after write");
  endtask

  initial begin
    @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      slow_grade = g[0];
      run_grade(g);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule